// File: doc/BRIEF.md
# Receive Byte Queue with Sticky Interrupt Flags

The block buffers bytes handed over by a serial slave receiver until software collects them. A push strobe with a data byte stores one entry, and a pop strobe takes out the oldest one. The popped byte appears on `pop_data` one cycle after the pop. Storage holds eight bytes. A master enable bit in the control register gates the whole queue. While that bit is 0, arriving bytes are discarded and the queue is held empty.

A small fill-state machine follows the queue through the states OFF, EMPTY, PARTIAL and FULL. It takes these transitions:
- OFF to EMPTY, or OFF to PARTIAL when a push lands in the same cycle, once the queue is enabled.
- EMPTY to PARTIAL on a push.
- PARTIAL to FULL when the eighth byte is stored.
- FULL to PARTIAL on a pop.
- PARTIAL to EMPTY when the last byte leaves. This transition is the empty event.
- Any state to OFF when the enable bit is cleared. This transition flushes the queue.

Besides the empty event, the block reports a threshold event whenever the level becomes 4 and a full event when it reaches 8. Each event sets a sticky status flag. Software clears a flag by writing 0 to it. Software may also write 1 to a flag to force an interrupt. The `irq` output is the registered OR of every flag ANDed with its own enable bit.

Registers are reached through a 2-bit address, a write strobe and a combinational read port:
- Address 0, control: bit 7 enables the queue, bit 3 enables the full interrupt, bit 1 enables the threshold interrupt, bit 0 enables the empty interrupt.
- Address 1, status: bit 4 is overflow, bit 3 full, bit 1 threshold, bit 0 empty.
- Address 2, level: the current fill level in bits 3:0. This register is read-only.

Top module: `rx_byte_queue`

## Requirements
- R1: After reset, the control, status and level registers all read 0, and `irq` and `pop_data` are 0.
- R2: Bytes leave in the order they were pushed. A popped byte appears on `pop_data` in the cycle after the pop, and the level never exceeds 8.
- R3: While control bit 7 is 0, pushes are not stored. Clearing bit 7 flushes the queue, so the level reads 0 and later pops return 0.
- R4: Status bit 1 (threshold) becomes 1 in the cycle the level changes to 4 from any other value.
- R5: Status bit 3 (full) becomes 1 when the level changes to 8. A push while full without a pop is dropped, leaves the level at 8 and sets status bit 4 (overflow).
- R6: Status bit 0 (empty) becomes 1 when a pop removes the last byte. Flushing the queue through the enable bit does not set it.
- R7: Status flags are sticky. Writing 0 to a flag clears it and writing 1 sets it. A hardware event in the same cycle as a software clear leaves the flag at 1.
- R8: `irq` equals, one cycle later, the OR of full AND control bit 3, threshold AND control bit 1, and empty AND control bit 0.
- R9: A pop while the queue is empty returns 0 on `pop_data` and leaves the level unchanged.
- R10: A push and a pop in the same cycle on a non-empty queue leave the level unchanged and keep first-in first-out order.
- R11: Unused register bits read as 0 and ignore writes. Writing 0xFF to control reads back 0x8B, and writing 0xFF to status reads back 0x1B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Byte arrival strobe from the serial receiver |
| push_data | input | 8 | Arriving byte |
| pop | input | 1 | Software read strobe |
| pop_data | output | 8 | Popped byte, valid the cycle after `pop` |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 status, 2 level) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Registered interrupt request |

## Verification
The queue is exercised with several input patterns:
- A run of isolated pushes that crosses the threshold and then fills the queue, which separates the threshold event from the full event.
- One extra push at capacity, which exposes a dropped byte and the overflow flag.
- A complete drain, which shows the ordering, the threshold event on the way down and the empty event.

Further patterns cover the corner cases:
- Pops into an empty queue, which show that 0 is returned and that the level does not underflow.
- Paired push-and-pop cycles, which show that the level stays put and that the order holds.
- A push that lands on the threshold in the same cycle as a software clear, which exposes the priority rule.

A scoreboard queue predicts every popped byte, so any reordering, loss or duplication is caught at the moment the byte appears.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_STAT  = 2'd1;
    localparam logic [1:0] ADDR_LEVEL = 2'd2;

    localparam int BIT_ON    = 7;
    localparam int BIT_OVF   = 4;
    localparam int BIT_FULL  = 3;
    localparam int BIT_THR   = 1;
    localparam int BIT_EMPTY = 0;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_EMPTY = 2'd1,
        ST_PART  = 2'd2,
        ST_FULL  = 2'd3
    } fill_state_e;

    typedef struct packed {
        logic ovf;
        logic full;
        logic thr;
        logic empty;
    } rxq_flags_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr,
    input  logic             rd,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr) wr_ptr <= step(wr_ptr);
            if (rd) rd_ptr <= step(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (wr) mem[wr_ptr] <= wdata;
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/rxq_fsm.sv
module rxq_fsm
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int THRESH = 4,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             on,
    input  logic             push,
    input  logic             pop,
    output logic             do_push,
    output logic             do_pop,
    output logic             flush,
    output logic [CNT_W-1:0] level,
    output logic             ev_thr,
    output logic             ev_full,
    output logic             ev_empty,
    output logic             ev_ovf
);
    localparam logic [CNT_W-1:0] LVL_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] LVL_THR  = CNT_W'(THRESH);

    fill_state_e      state_q, state_n;
    logic [CNT_W-1:0] lvl_q, lvl_n;

    function automatic fill_state_e classify(input logic [CNT_W-1:0] l);
        if (l == '0)            return ST_EMPTY;
        else if (l == LVL_FULL) return ST_FULL;
        else                    return ST_PART;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            lvl_q   <= '0;
        end else begin
            state_q <= state_n;
            lvl_q   <= lvl_n;
        end
    end

    // outputs and next state
    always_comb begin
        do_pop  = on && pop && (state_q == ST_PART || state_q == ST_FULL);
        do_push = on && push && (state_q != ST_FULL || do_pop);
        ev_ovf  = on && push && !do_push;
        flush   = !on;
        if (!on) lvl_n = '0;
        else     lvl_n = lvl_q + CNT_W'(do_push) - CNT_W'(do_pop);

        unique case (state_q)
            ST_OFF:   state_n = on ? classify(lvl_n) : ST_OFF;
            ST_EMPTY: state_n = on ? classify(lvl_n) : ST_OFF;
            ST_PART:  state_n = on ? classify(lvl_n) : ST_OFF;
            ST_FULL:  state_n = on ? classify(lvl_n) : ST_OFF;
            default:  state_n = ST_OFF;
        endcase

        ev_empty = (state_q == ST_PART || state_q == ST_FULL) && state_n == ST_EMPTY;
        ev_full  = (state_q != ST_FULL) && state_n == ST_FULL;
        ev_thr   = on && (lvl_q != LVL_THR) && (lvl_n == LVL_THR);
        level    = lvl_q;
    end
endmodule

// File: rtl/rxq_regs.sv
module rxq_regs
    import rxq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    input  logic [CNT_W-1:0] level,
    input  logic             ev_thr,
    input  logic             ev_full,
    input  logic             ev_empty,
    input  logic             ev_ovf,
    output logic [7:0]       rdata,
    output logic             ctrl_on,
    output logic [2:0]       ctrl_ie,
    output rxq_flags_t       flags,
    output logic             irq
);
    logic       wr_ctrl, wr_stat;
    rxq_flags_t flags_n;
    logic       unused_bits;

    assign wr_ctrl     = wr && (addr == ADDR_CTRL);
    assign wr_stat     = wr && (addr == ADDR_STAT);
    assign unused_bits = ^{wdata[6:5], wdata[2]};

    function automatic logic sticky(input logic cur, input logic sw_wr,
                                    input logic sw_val, input logic hw_set);
        logic v;
        v = sw_wr ? sw_val : cur;
        return v | hw_set;
    endfunction

    always_comb begin
        flags_n.ovf   = sticky(flags.ovf,   wr_stat, wdata[BIT_OVF],   ev_ovf);
        flags_n.full  = sticky(flags.full,  wr_stat, wdata[BIT_FULL],  ev_full);
        flags_n.thr   = sticky(flags.thr,   wr_stat, wdata[BIT_THR],   ev_thr);
        flags_n.empty = sticky(flags.empty, wr_stat, wdata[BIT_EMPTY], ev_empty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_on <= 1'b0;
            ctrl_ie <= '0;
            flags   <= '0;
            irq     <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_on <= wdata[BIT_ON];
                ctrl_ie <= {wdata[BIT_FULL], wdata[BIT_THR], wdata[BIT_EMPTY]};
            end
            flags <= flags_n;
            irq   <= (flags.full & ctrl_ie[2]) | (flags.thr & ctrl_ie[1])
                   | (flags.empty & ctrl_ie[0]);
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_CTRL: begin
                rdata[BIT_ON]    = ctrl_on;
                rdata[BIT_FULL]  = ctrl_ie[2];
                rdata[BIT_THR]   = ctrl_ie[1];
                rdata[BIT_EMPTY] = ctrl_ie[0];
            end
            ADDR_STAT: begin
                rdata[BIT_OVF]   = flags.ovf;
                rdata[BIT_FULL]  = flags.full;
                rdata[BIT_THR]   = flags.thr;
                rdata[BIT_EMPTY] = flags.empty;
            end
            ADDR_LEVEL: rdata[CNT_W-1:0] = level;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
    import rxq_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int DEPTH  = 8,
    parameter int THRESH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             ctrl_on, do_push, do_pop, flush;
    logic             ev_thr, ev_full, ev_empty, ev_ovf;
    logic [2:0]       ctrl_ie;
    logic [CNT_W-1:0] level;
    logic [WIDTH-1:0] head;
    rxq_flags_t       flags;

    rxq_fsm #(.DEPTH(DEPTH), .THRESH(THRESH), .CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .on(ctrl_on), .push(push), .pop(pop),
        .do_push(do_push), .do_pop(do_pop), .flush(flush), .level(level),
        .ev_thr(ev_thr), .ev_full(ev_full), .ev_empty(ev_empty), .ev_ovf(ev_ovf)
    );

    rxq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) store_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr(do_push), .rd(do_pop),
        .wdata(push_data), .head(head)
    );

    rxq_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .level(level), .ev_thr(ev_thr), .ev_full(ev_full), .ev_empty(ev_empty),
        .ev_ovf(ev_ovf), .rdata(reg_rdata), .ctrl_on(ctrl_on), .ctrl_ie(ctrl_ie),
        .flags(flags), .irq(irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pop_data <= '0;
        else if (do_pop) pop_data <= head;
        else if (pop)    pop_data <= '0;
    end
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int WIDTH  = 8,
    parameter int DEPTH  = 8,
    parameter int THRESH = 4,
    parameter int CNT_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push,
    input logic             pop,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic             ctrl_on,
    input logic [2:0]       ctrl_ie,
    input logic [CNT_W-1:0] level,
    input logic             f_full,
    input logic             f_thr,
    input logic             f_ovf,
    input logic [WIDTH-1:0] pop_data,
    input logic             irq
);
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH)); // R2
    AST_OFF_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_on |=> level == '0); // R3
    AST_THR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_on && level == CNT_W'(THRESH - 1) && push && !pop) |=> f_thr); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_on && level == CNT_W'(DEPTH) && push && !pop) |=> (level == CNT_W'(DEPTH) && f_ovf)); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (f_full && !(reg_wr && reg_addr == 2'd1)) |=> f_full); // R7
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_ie == 3'b000) |=> !irq); // R8
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_on && level == '0 && pop && !push) |=> (pop_data == '0 && level == '0)); // R9
    AST_SWAP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_on && level != '0 && push && pop) |=> $stable(level)); // R10
endmodule

bind rx_byte_queue rxq_checker #(
    .WIDTH(WIDTH), .DEPTH(DEPTH), .THRESH(THRESH), .CNT_W(CNT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .ctrl_on(ctrl_on), .ctrl_ie(ctrl_ie), .level(level),
    .f_full(flags.full), .f_thr(flags.thr), .f_ovf(flags.ovf),
    .pop_data(pop_data), .irq(irq)
);

// File: tb/rx_byte_queue_tb_top.sv
module rx_byte_queue_tb_top;
    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push = 1'b0;
    logic [7:0] push_data = '0;
    logic       pop = 1'b0;
    logic [7:0] pop_data;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit en_m = 1'b0;
    logic [7:0] sb_q [$];

    always #2 clk = ~clk;

    rx_byte_queue dut_i (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .pop_data(pop_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor and scoreboard: model the queue at each edge, compare popped bytes
    always @(posedge clk) begin
        if (rst_n) begin
            automatic logic       p  = pop;
            automatic logic       u  = push;
            automatic logic [7:0] d  = push_data;
            automatic logic       w  = reg_wr;
            automatic logic [1:0] a  = reg_addr;
            automatic logic [7:0] wd = reg_wdata;
            automatic logic [7:0] exp = '0;
            if (en_m) begin
                if (p && sb_q.size() > 0) exp = sb_q.pop_front();
                if (u && sb_q.size() < DEPTH) sb_q.push_back(d);
            end
            if (w && a == 2'd0) begin
                en_m = wd[7];
                if (!wd[7]) sb_q.delete();
            end
            if (p) begin
                #1;
                chk("R2/R9/R10 popped byte", {24'd0, pop_data}, {24'd0, exp});
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drv_push(input logic [7:0] d);
        @(negedge clk); push = 1'b1; push_data = d;
        @(negedge clk); push = 1'b0;
    endtask

    task automatic drv_pop();
        @(negedge clk); pop = 1'b1;
        @(negedge clk); pop = 1'b0;
    endtask

    task automatic drv_both(input logic [7:0] d);
        @(negedge clk); push = 1'b1; push_data = d; pop = 1'b1;
        @(negedge clk); push = 1'b0; pop = 1'b0;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(2'd0, v); chk("R1 ctrl", v, 8'h00);
        reg_read(2'd1, v); chk("R1 status", v, 8'h00);
        reg_read(2'd2, v); chk("R1 level", v, 8'h00);
        chk("R1 irq", irq, 1'b0);
        chk("R1 pop_data", pop_data, 8'h00);

        // R3 pushes ignored while disabled
        drv_push(8'h11); drv_push(8'h22); drv_push(8'h33);
        reg_read(2'd2, v); chk("R3 level while off", v, 8'h00);

        // R4 threshold at four bytes, irq masked (R8)
        reg_write(2'd0, 8'h80);
        for (int i = 0; i < 4; i++) drv_push(8'hA0 + 8'(i));
        reg_read(2'd1, v); chk("R4 threshold flag", v, 8'h02);
        idle(1); chk("R8 irq masked", irq, 1'b0);
        reg_write(2'd0, 8'h82); idle(1);
        chk("R8 irq on threshold", irq, 1'b1);
        reg_write(2'd1, 8'h00); idle(1);
        chk("R7 software clear drops irq", irq, 1'b0);

        // R5 full and overflow
        for (int i = 4; i < 8; i++) drv_push(8'hA0 + 8'(i));
        reg_read(2'd1, v); chk("R5 full flag", v, 8'h08);
        drv_push(8'hEE);
        reg_read(2'd1, v); chk("R5 overflow flag", v, 8'h18);
        reg_read(2'd2, v); chk("R5 level stays 8", v, 8'h08);

        // R2 drain in order, R6 empty event, R4 threshold on the way down
        for (int i = 0; i < 8; i++) drv_pop();
        reg_read(2'd1, v); chk("R6 empty after drain", v, 8'h1B);

        // R9 pop on empty
        drv_pop();
        reg_read(2'd2, v); chk("R9 level after empty pop", v, 8'h00);

        // R10 simultaneous push and pop
        drv_push(8'h51); drv_push(8'h52);
        drv_both(8'h53); drv_both(8'h54); drv_both(8'h55);
        reg_read(2'd2, v); chk("R10 level unchanged", v, 8'h02);
        drv_pop(); drv_pop();

        // R7 software set, R8 irq from forced flag
        reg_write(2'd1, 8'h00);
        reg_write(2'd1, 8'h01);
        reg_read(2'd1, v); chk("R7 software set", v, 8'h01);
        reg_write(2'd0, 8'h81); idle(1);
        chk("R8 irq on forced empty", irq, 1'b1);

        // R7 hardware set wins over same-cycle clear
        reg_write(2'd0, 8'h00);
        reg_write(2'd0, 8'h80);
        reg_write(2'd1, 8'h00);
        drv_push(8'h61); drv_push(8'h62); drv_push(8'h63);
        @(negedge clk);
        push = 1'b1; push_data = 8'h64;
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h00;
        @(negedge clk);
        push = 1'b0; reg_wr = 1'b0;
        reg_read(2'd1, v); chk("R7 set beats clear", v, 8'h02);

        // R11 unused bits
        reg_write(2'd0, 8'hFF);
        reg_read(2'd0, v); chk("R11 ctrl readback", v, 8'h8B);
        reg_write(2'd1, 8'hFF);
        reg_read(2'd1, v); chk("R11 status readback", v, 8'h1B);
        reg_read(2'd3, v); chk("R11 unmapped address", v, 8'h00);

        // R3 disable flushes, R6 flush raises no empty event
        reg_write(2'd1, 8'h00);
        reg_write(2'd0, 8'h00); idle(1);
        reg_read(2'd2, v); chk("R3 flush level", v, 8'h00);
        reg_read(2'd1, v); chk("R6 no empty on flush", v, 8'h00);
        drv_pop();
        drv_push(8'h77);
        reg_read(2'd2, v); chk("R3 push after disable", v, 8'h00);

        idle(2);
        summary();
    end
endmodule